// File: doc/BRIEF.md
# Direct Digital Synthesis Sine Generator

This block produces a digitally synthesized sine wave for an external DAC. A 32-bit tuning word is shifted in one bit at a time over a three-wire port (data, strobe, latch). A latch pulse then applies the collected word as the active frequency setting in a single cycle. On every clock the block adds the active word to a 32-bit phase register that wraps around. The output frequency is therefore word × f_clk / 2^32.

Only the ten most significant phase bits are used for addressing. Two of them select a quarter of the wave, and eight of them index a built-in 256-entry quarter-wave amplitude table. The block mirrors the index and inverts the sign as the quarter requires. The result is a registered 12-bit two's-complement sample with a valid flag. Changing the tuning word never disturbs the running phase, so frequency hops are phase-continuous.

Top module: `dds_synth`

## Requirements
- R1: Each clock with `ser_strobe_i` high shifts `ser_data_i` into bit 0 of a 32-bit shift register, with the older bits moving one place toward bit 31. A word is therefore sent most significant bit first in 32 strobes. Shifting alone does not change the output frequency.
- R2: A clock with `ser_latch_i` high copies the shift register into the active tuning word. If a strobe falls in the same cycle, the copied value is the shift register as it stood before that strobe's bit entered.
- R3: On every clock the phase register becomes (phase + active word) mod 2^32. A latch changes the increment from the following clock onward, and it never reloads or clears the phase.
- R4: Phase bits [31:30] select the quarter, and phase bits [29:22] give the table index k. Bits [21:0] do not affect the sample.
- R5: With T[j] = round(2047·sin((2j+1)·π/1024)) for j in 0..255, the sample is +T[k] in quarter 0, +T[255−k] in quarter 1, −T[k] in quarter 2 and −T[255−k] in quarter 3.
- R6: The sample seen after clock edge e is computed from the phase register value that was present after edge e−2. The latency is fixed at two cycles.
- R7: `sample_valid_o` is low while reset is applied. It goes high on the fourth rising edge after `rst_n` rises and then stays high every cycle.
- R8: A low `rst_n` asynchronously clears the phase, the shift register, the active word, the pipeline and `sample_o`. Its release passes through a two-flop synchronizer. After reset, with no load, the sample stays at T[0] = 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_data_i | input | 1 | Serial tuning-word bit |
| ser_strobe_i | input | 1 | Shift enable for the serial bit |
| ser_latch_i | input | 1 | Apply the shift register as the active word |
| sample_o | output | 12 | Signed sine sample for the DAC |
| sample_valid_o | output | 1 | Sample is valid this cycle |

## Verification
The latch and the strobe can arrive in the same cycle. To provoke this, the bench sends 31 bits of a word and then raises the final strobe and the latch together. The bench model applies the pre-strobe shift contents, and every later sample is compared against the phase that word produces.

A second collision occurs when a latch changes the increment while the accumulator runs. Every sample before, during and after each latch is compared to a phase model that keeps running across the change. Any reload of the phase or any one-cycle slip in applying the new word is therefore reported.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam int unsigned PHASE_W_DEF = 32;
  localparam int unsigned ADDR_W_DEF  = 10;
  localparam int unsigned AMP_W_DEF   = 12;

  // Quarter of the sine period selected by the two top phase bits
  typedef enum logic [1:0] {
    Q_RISE     = 2'd0,
    Q_FALL     = 2'd1,
    Q_NEG_FALL = 2'd2,
    Q_NEG_RISE = 2'd3
  } quad_e;
endpackage

// File: rtl/dds_tw_loader.sv
module dds_tw_loader #(
  parameter int unsigned W = dds_pkg::PHASE_W_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         data_i,
  input  logic         strobe_i,
  input  logic         latch_i,
  output logic [W-1:0] tw_o
);
  logic [W-1:0] shift_q, shift_d;
  logic [W-1:0] tw_q, tw_d;

  always_comb begin
    shift_d = shift_q;
    tw_d    = tw_q;
    if (strobe_i) shift_d = {shift_q[W-2:0], data_i};
    if (latch_i)  tw_d    = shift_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      tw_q    <= '0;
    end else begin
      shift_q <= shift_d;
      tw_q    <= tw_d;
    end
  end

  assign tw_o = tw_q;

  p_shift_in_r1: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_i |=> shift_q[0] == $past(data_i));
  p_tw_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_i |=> $stable(tw_q));
  p_tw_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    latch_i |=> tw_q == $past(shift_q));
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int unsigned PHASE_W = dds_pkg::PHASE_W_DEF,
  parameter int unsigned ADDR_W  = dds_pkg::ADDR_W_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PHASE_W-1:0] tw_i,
  output logic [ADDR_W-1:0]  phase_top_o
);
  logic [PHASE_W-1:0] phase_q, phase_d;

  always_comb phase_d = phase_q + tw_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign phase_top_o = phase_q[PHASE_W-1 -: ADDR_W];

  p_phase_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> phase_q == $past(phase_q) + $past(tw_i));
endmodule

// File: rtl/dds_sine_lut.sv
module dds_sine_lut #(
  parameter int unsigned ADDR_W = dds_pkg::ADDR_W_DEF,
  parameter int unsigned AMP_W  = dds_pkg::AMP_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [AMP_W-1:0]  sample_o
);
  import dds_pkg::*;

  localparam int unsigned IDX_W  = ADDR_W - 2;
  localparam int unsigned QDEPTH = 1 << IDX_W;
  localparam int unsigned MAG_W  = AMP_W - 1;
  localparam int unsigned PEAK   = (1 << MAG_W) - 1;
  localparam real         PI     = 3.14159265358979323846;

  // Quarter-wave magnitude table, sampled at bin centres for exact mirroring
  logic [MAG_W-1:0] rom [QDEPTH];
  for (genvar k = 0; k < QDEPTH; k++) begin : g_rom
    localparam int VAL = $rtoi(real'(PEAK) *
                               $sin((2.0 * k + 1.0) * PI / (4.0 * QDEPTH)) + 0.5);
    assign rom[k] = MAG_W'(VAL);
  end

  // Stage 1: quarter decode and index mirroring
  quad_e            quad_q, quad_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    quad_d = quad_e'(addr_i[ADDR_W-1 -: 2]);
    case (quad_d)
      Q_FALL, Q_NEG_RISE: idx_d = ~addr_i[IDX_W-1:0];
      default:            idx_d =  addr_i[IDX_W-1:0];
    endcase
  end

  // Stage 2: table read and sign
  logic [AMP_W-1:0] mag_ext;
  logic [AMP_W-1:0] sample_q, sample_d;

  always_comb begin
    mag_ext = {1'b0, rom[idx_q]};
    case (quad_q)
      Q_NEG_FALL, Q_NEG_RISE: sample_d = -mag_ext;
      default:                sample_d =  mag_ext;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quad_q   <= Q_RISE;
      idx_q    <= '0;
      sample_q <= '0;
    end else begin
      quad_q   <= quad_d;
      idx_q    <= idx_d;
      sample_q <= sample_d;
    end
  end

  assign sample_o = sample_q;

  p_neg_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
    quad_q[1] |=> sample_q[AMP_W-1]);
  p_pos_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !quad_q[1] |=> !sample_q[AMP_W-1]);
  p_no_min_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_q != {1'b1, {(AMP_W-1){1'b0}}});
endmodule

// File: rtl/dds_synth.sv
module dds_synth #(
  parameter int unsigned PHASE_W = dds_pkg::PHASE_W_DEF,
  parameter int unsigned ADDR_W  = dds_pkg::ADDR_W_DEF,
  parameter int unsigned AMP_W   = dds_pkg::AMP_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_data_i,
  input  logic             ser_strobe_i,
  input  logic             ser_latch_i,
  output logic [AMP_W-1:0] sample_o,
  output logic             sample_valid_o
);
  localparam int unsigned LAT = 2;

  // Reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [PHASE_W-1:0] tw;
  logic [ADDR_W-1:0]  phase_top;

  dds_tw_loader #(.W(PHASE_W)) u_loader (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .data_i   (ser_data_i),
    .strobe_i (ser_strobe_i),
    .latch_i  (ser_latch_i),
    .tw_o     (tw)
  );

  dds_phase_acc #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W)) u_acc (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .tw_i        (tw),
    .phase_top_o (phase_top)
  );

  dds_sine_lut #(.ADDR_W(ADDR_W), .AMP_W(AMP_W)) u_lut (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .addr_i   (phase_top),
    .sample_o (sample_o)
  );

  // Valid follows the table pipeline depth
  logic [LAT-1:0] vld_q, vld_d;
  always_comb vld_d = {vld_q[LAT-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) vld_q <= '0;
    else            vld_q <= vld_d;
  end
  assign sample_valid_o = vld_q[LAT-1];

  p_valid_stays_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    sample_valid_o |=> sample_valid_o);
  p_reset_quiet_r8: assert property (@(posedge clk)
    !rst_n |-> (sample_o == '0 && !sample_valid_o));
endmodule

// File: tb/sim_dds_synth.sv
module sim_dds_synth;
  localparam time CLK_P = 20ns;
  localparam real PI = 3.14159265358979323846;

  // {tuning word, cycles to run}
  localparam logic [63:0] VEC [7] = '{
    {32'h0040_0000, 32'd1100},
    {32'h0100_0000, 32'd300},
    {32'h4000_0000, 32'd12},
    {32'h8000_0000, 32'd10},
    {32'hFFC0_0000, 32'd600},
    {32'h1234_5678, 32'd200},
    {32'h0000_0001, 32'd50}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_data = 1'b0;
  logic        ser_strobe = 1'b0;
  logic        ser_latch = 1'b0;
  logic [11:0] sample;
  logic        sample_valid;

  int nchk = 0;
  int nerr = 0;
  bit chk_en = 1'b0;
  bit done = 1'b0;
  string cur_req = "R3 R5 R6";

  always #(CLK_P / 2) clk = ~clk;

  dds_synth u0 (
    .clk            (clk),
    .rst_n          (rst_n),
    .ser_data_i     (ser_data),
    .ser_strobe_i   (ser_strobe),
    .ser_latch_i    (ser_latch),
    .sample_o       (sample),
    .sample_valid_o (sample_valid)
  );

  task automatic check(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_sample(logic [31:0] p);
    int k;
    int j;
    int m;
    k = int'(p[29:22]);
    j = p[30] ? 255 - k : k;
    m = $rtoi(2047.0 * $sin((2.0 * j + 1.0) * PI / 1024.0) + 0.5);
    return p[31] ? -m : m;
  endfunction

  // Reference model driven only by the bench's own inputs
  logic [31:0] mphase, mtw, mshift;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mphase <= '0;
      mtw    <= '0;
      mshift <= '0;
    end else begin
      mphase <= mphase + mtw;
      if (ser_latch)  mtw    <= mshift;
      if (ser_strobe) mshift <= {mshift[30:0], ser_data};
    end
  end

  logic [31:0] h1, h2;
  always @(negedge clk) begin
    if (!rst_n) begin
      h1 = '0;
      h2 = '0;
    end else begin
      if (chk_en) begin
        check({cur_req, " sample"}, int'($signed(sample)), exp_sample(h2));
        check("R7 valid", int'(sample_valid), 1);
      end
      h2 = h1;
      h1 = mphase;
    end
  end

  task automatic load_word(logic [31:0] w);
    for (int i = 31; i >= 0; i--) begin
      ser_data   = w[i];
      ser_strobe = 1'b1;
      @(negedge clk);
    end
    ser_strobe = 1'b0;
    ser_data   = 1'b0;
  endtask

  task automatic pulse_latch();
    ser_latch = 1'b1;
    @(negedge clk);
    ser_latch = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    // R8 / R7: reset state
    repeat (3) @(negedge clk);
    check("R8 sample in reset", int'(sample), 0);
    check("R7 valid in reset", int'(sample_valid), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 valid after third edge", int'(sample_valid), 0);
    @(negedge clk);
    check("R7 valid after fourth edge", int'(sample_valid), 1);
    check("R8 tuning word cleared, sample T[0]", int'($signed(sample)), 6);
    chk_en = 1'b1;

    // R8: latch with an empty shift register keeps the word at zero
    cur_req = "R8 empty latch";
    pulse_latch();
    repeat (10) @(negedge clk);

    // Main vector walk: R3 R4 R5 R6, phase-continuous hops
    foreach (VEC[v]) begin
      cur_req = "R3 R4 R5 R6 vector";
      load_word(VEC[v][63:32]);
      pulse_latch();
      repeat (int'(VEC[v][31:0])) @(negedge clk);
    end

    // R1: shifting without latching leaves the frequency untouched
    cur_req = "R1 shift without latch";
    load_word(32'h2000_0000);
    repeat (40) @(negedge clk);

    // R2: latch coincides with the final strobe
    cur_req = "R2 latch with strobe";
    load_word(32'h0300_0000);
    for (int i = 30; i >= 0; i--) begin
      ser_data   = i[0];
      ser_strobe = 1'b1;
      @(negedge clk);
    end
    ser_data   = 1'b1;
    ser_strobe = 1'b1;
    ser_latch  = 1'b1;
    @(negedge clk);
    ser_strobe = 1'b0;
    ser_latch  = 1'b0;
    ser_data   = 1'b0;
    repeat (60) @(negedge clk);
    cur_req = "R2 second latch";
    pulse_latch();
    repeat (60) @(negedge clk);

    // R8: asynchronous reset mid-run
    #3ns;
    chk_en = 1'b0;
    rst_n  = 1'b0;
    #1ns;
    check("R8 async clear sample", int'(sample), 0);
    check("R8 async clear valid", int'(sample_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R8 sample after reset", int'($signed(sample)), 6);
    cur_req = "R8 post reset";
    chk_en = 1'b1;
    repeat (20) @(negedge clk);

    chk_en = 1'b0;
    finish_run();
  end
endmodule